// File: doc/BRIEF.md
# Bus-Matching Read Port Unpacker

This block sits between the read side of a 36-bit FIFO and a read port whose width can be 36, 18 or 9 bits. The FIFO presents its head long word on `fifoWord`. The unpacker cuts that word into one, two or four parts and shows the current part on `rdData`, with the unused upper bits forced to zero. Each accepted read moves to the next part. The read of the last part raises `popStrobe` for one cycle, which tells the FIFO to advance to its next long word.

The width is set by two static inputs. With `busMatch` low, the port runs at the full 36 bits. With `busMatch` high, `sizeSel` picks 9-bit parts (high) or 18-bit parts (low). The part order is set by `endianIn`, which is captured on every clock edge while `rstN` is low and is ignored after that. A captured high gives most-significant-part-first order. A captured low gives least-significant-part-first order. `rdOe` marks when the port would drive its pads.

Top module: `bus_match_unpacker`

## Requirements
- R1: With `busMatch`=0, `rdData` equals `fifoWord` and every accepted read raises `popStrobe`.
- R2: With `busMatch`=1 and `sizeSel`=1, each long word is read as four 9-bit parts on `rdData[8:0]`, with `rdData[35:9]` zero. `popStrobe` is high only on the fourth read.
- R3: With `busMatch`=1 and `sizeSel`=0, each long word is read as two 18-bit parts on `rdData[17:0]`, with `rdData[35:18]` zero. `popStrobe` is high only on the second read.
- R4: If `endianIn` was 1 during reset, parts come out most significant first. In byte mode the order is bits [35:27], [26:18], [17:9], [8:0]. In halfword mode it is [35:18], then [17:0].
- R5: If `endianIn` was 0 during reset, parts come out least significant first. In byte mode the order is [8:0], [17:9], [26:18], [35:27]. In halfword mode it is [17:0], then [35:18].
- R6: A read is accepted on a rising edge only when `csN`=0 and `rdEn`=1. At any other edge the part position holds and `popStrobe` is 0.
- R7: `rdOe` is 1 exactly when `csN` is 0.
- R8: A clock edge with `rstN`=0 returns the part position to the first part, even in the middle of a word.
- R9: A change of `endianIn` after reset has no effect on the part order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rstN | input | 1 | Synchronous master reset, active low. `endianIn` is sampled while it is low |
| endianIn | input | 1 | Part order select, captured during reset (1 = most significant first) |
| busMatch | input | 1 | 0 = 36-bit port, 1 = narrow port |
| sizeSel | input | 1 | Narrow width when `busMatch`=1: 1 = 9-bit, 0 = 18-bit |
| csN | input | 1 | Chip select, active low |
| rdEn | input | 1 | Read enable, active high |
| fifoWord | input | 36 | Head long word from the FIFO |
| rdData | output | 36 | Current part, zero-extended |
| rdOe | output | 1 | Output enable for the pad drivers |
| popStrobe | output | 1 | Tells the FIFO to advance its head |

## Verification
Two things happen at the same edge when the last part of a word is read. `popStrobe` is raised, and the part position wraps back to the first part. The bench models the FIFO so that the head word changes right after every pop edge. The very next read must then show the first part of the new word, in the selected order. A failed wrap, a missing pop or a stale slice shows up as a wrong part or an early or late pop. The bench also blocks reads with `csN` or `rdEn` in the middle of a word and confirms that no part is skipped.

// File: rtl/bm_unpack_pkg.sv
package bm_unpack_pkg;
  typedef enum logic [1:0] {
    WM_LONG = 2'd0,
    WM_HALF = 2'd1,
    WM_BYTE = 2'd2
  } widthMode_e;

  typedef struct packed {
    logic accept;
    logic lastPart;
  } strobes_t;
endpackage

// File: rtl/bmu_ctrl.sv
module bmu_ctrl
  import bm_unpack_pkg::*;
#(
  parameter int QUARTERS = 4,
  localparam int IDX_W = $clog2(QUARTERS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             endianIn,
  input  logic             busMatch,
  input  logic             sizeSel,
  input  logic             csN,
  input  logic             rdEn,
  output widthMode_e       mode,
  output logic [IDX_W-1:0] sliceIdx,
  output strobes_t         stb
);
  logic             endianQ;
  logic [IDX_W-1:0] partCnt;
  logic [IDX_W-1:0] lastIdx;

  always_comb begin
    if (!busMatch)    mode = WM_LONG;
    else if (sizeSel) mode = WM_BYTE;
    else              mode = WM_HALF;
  end

  always_comb begin
    unique case (mode)
      WM_BYTE: lastIdx = IDX_W'(QUARTERS - 1);
      WM_HALF: lastIdx = IDX_W'(1);
      default: lastIdx = '0;
    endcase
  end

  assign stb.accept   = !csN && rdEn;
  assign stb.lastPart = (partCnt == lastIdx);
  assign sliceIdx     = endianQ ? (lastIdx - partCnt) : partCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      endianQ <= endianIn;
      partCnt <= '0;
    end else if (stb.accept) begin
      partCnt <= stb.lastPart ? '0 : partCnt + 1'b1;
    end
  end

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN || !rdEn) |=> $stable(partCnt));
  // R8
  reset_clears_pos_chk: assert property (@(posedge clk)
    !rstN |=> (partCnt == '0));
  // R9
  endian_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(endianQ));
  // R2
  pos_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    partCnt <= lastIdx);
  // R1
  long_single_part_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busMatch |-> (partCnt == '0));
endmodule

// File: rtl/bmu_datapath.sv
module bmu_datapath
  import bm_unpack_pkg::*;
#(
  parameter int WORD_W   = 36,
  parameter int QUARTERS = 4,
  localparam int LANE_W = WORD_W / QUARTERS,
  localparam int HALF_W = WORD_W / 2,
  localparam int IDX_W  = $clog2(QUARTERS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] fifoWord,
  input  widthMode_e        mode,
  input  logic [IDX_W-1:0]  sliceIdx,
  output logic [WORD_W-1:0] rdData
);
  logic [LANE_W-1:0] quarterLane [QUARTERS];
  logic [HALF_W-1:0] halfLane    [2];

  for (genvar q = 0; q < QUARTERS; q++) begin : g_quarter
    assign quarterLane[q] = fifoWord[q*LANE_W +: LANE_W];
  end
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign halfLane[h] = fifoWord[h*HALF_W +: HALF_W];
  end

  always_comb begin
    rdData = '0;
    unique case (mode)
      WM_BYTE: rdData[LANE_W-1:0] = quarterLane[sliceIdx];
      WM_HALF: rdData[HALF_W-1:0] = halfLane[sliceIdx[0]];
      default: rdData = fifoWord;
    endcase
  end

  // R2
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == WM_BYTE) |-> (rdData[WORD_W-1:LANE_W] == '0));
  // R3
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == WM_HALF) |-> (rdData[WORD_W-1:HALF_W] == '0));
endmodule

// File: rtl/bus_match_unpacker.sv
module bus_match_unpacker
  import bm_unpack_pkg::*;
#(
  parameter int WORD_W   = 36,
  parameter int QUARTERS = 4,
  localparam int IDX_W = $clog2(QUARTERS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              endianIn,
  input  logic              busMatch,
  input  logic              sizeSel,
  input  logic              csN,
  input  logic              rdEn,
  input  logic [WORD_W-1:0] fifoWord,
  output logic [WORD_W-1:0] rdData,
  output logic              rdOe,
  output logic              popStrobe
);
  widthMode_e       mode;
  logic [IDX_W-1:0] sliceIdx;
  strobes_t         stb;

  bmu_ctrl #(.QUARTERS(QUARTERS)) u_ctrl (
    .clk(clk), .rstN(rstN), .endianIn(endianIn), .busMatch(busMatch),
    .sizeSel(sizeSel), .csN(csN), .rdEn(rdEn),
    .mode(mode), .sliceIdx(sliceIdx), .stb(stb)
  );

  bmu_datapath #(.WORD_W(WORD_W), .QUARTERS(QUARTERS)) u_dp (
    .clk(clk), .rstN(rstN), .fifoWord(fifoWord), .mode(mode),
    .sliceIdx(sliceIdx), .rdData(rdData)
  );

  assign popStrobe = stb.accept && stb.lastPart;
  assign rdOe      = !csN;

  // R6
  pop_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    popStrobe |-> (!csN && rdEn));
endmodule

// File: tb/bus_match_unpacker_test.sv
module bus_match_unpacker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        endianIn = 1'b0;
  logic        busMatch = 1'b0;
  logic        sizeSel = 1'b0;
  logic        csN = 1'b1;
  logic        rdEn = 1'b0;
  logic [35:0] fifoWord = '0;
  logic [35:0] rdData;
  logic        rdOe;
  logic        popStrobe;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bus_match_unpacker uut (
    .clk(clk), .rstN(rstN), .endianIn(endianIn), .busMatch(busMatch),
    .sizeSel(sizeSel), .csN(csN), .rdEn(rdEn), .fifoWord(fifoWord),
    .rdData(rdData), .rdOe(rdOe), .popStrobe(popStrobe)
  );

  // each entry: {busMatch, sizeSel, endian}
  localparam logic [5:0][2:0] MODE_TAB = {
    3'b000, 3'b001, 3'b100, 3'b101, 3'b110, 3'b111
  };

  function automatic logic [35:0] genWord(input int k);
    return 36'h9_A5C3_1E7B ^ (36'(k) * 36'h1_0F2E_3D4C) ^ {36'(k) << 20};
  endfunction

  function automatic int partCount(input logic bm, input logic sz);
    return !bm ? 1 : (sz ? 4 : 2);
  endfunction

  function automatic logic [35:0] expPart(input logic [35:0] w, input logic bm,
                                          input logic sz, input logic en, input int p);
    int n, idx, wd;
    logic [35:0] sh;
    n = partCount(bm, sz);
    if (n == 1) return w;
    wd = 36 / n;
    idx = en ? (n - 1 - p) : p;
    sh = w >> (idx * wd);
    return sh & ((36'h1 << wd) - 36'h1);
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic resetDut(input logic en);
    @(negedge clk);
    rstN = 1'b0; endianIn = en; csN = 1'b1; rdEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    endianIn = ~en; // R9: later changes must not matter
  endtask

  task automatic readStep(input logic [35:0] w, input logic [35:0] exp,
                          input logic expPop, input string tag);
    @(negedge clk);
    fifoWord = w; csN = 1'b0; rdEn = 1'b1;
    #1;
    chk({tag, " data"}, rdData, exp);
    chk({tag, " pop"}, {35'd0, popStrobe}, {35'd0, expPop});
    @(posedge clk);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [35:0] w;
    // R8 / R7: reset state
    resetDut(1'b0);
    #1;
    chk("R7 rdOe idle", {35'd0, rdOe}, 36'd0);
    chk("R8 no pop after reset", {35'd0, popStrobe}, 36'd0);

    // table walk over all width and order modes (R1..R5, R9)
    for (int m = 0; m < 6; m++) begin
      logic bm, sz, en;
      int n;
      {bm, sz, en} = MODE_TAB[m];
      busMatch = bm; sizeSel = sz;
      resetDut(en);
      n = partCount(bm, sz);
      for (int k = 0; k < 3; k++) begin
        w = genWord(k + m * 7);
        for (int p = 0; p < n; p++) begin
          readStep(w, expPart(w, bm, sz, en, p), (p == n - 1),
                   !bm ? "R1 long" : (sz ? (en ? "R2 R4 byte" : "R2 R5 byte")
                                         : (en ? "R3 R4 half" : "R3 R5 half")));
        end
      end
      #1;
      chk("R7 rdOe active", {35'd0, rdOe}, 36'd1);
    end

    // R4 explicit byte order spot check
    busMatch = 1'b1; sizeSel = 1'b1;
    resetDut(1'b1);
    readStep(36'hABC_DEF_123, 36'h157, 1'b0, "R4 first byte");

    // R6: blocked reads hold position
    resetDut(1'b0);
    w = 36'h1_2345_6789;
    readStep(w, expPart(w, 1, 1, 0, 0), 1'b0, "R6 part0");
    @(negedge clk);
    csN = 1'b1; rdEn = 1'b1;
    #1;
    chk("R6 cs high no pop", {35'd0, popStrobe}, 36'd0);
    chk("R7 rdOe off", {35'd0, rdOe}, 36'd0);
    @(negedge clk);
    csN = 1'b0; rdEn = 1'b0;
    #1;
    chk("R6 en low no pop", {35'd0, popStrobe}, 36'd0);
    readStep(w, expPart(w, 1, 1, 0, 1), 1'b0, "R6 part1 after hold");
    readStep(w, expPart(w, 1, 1, 0, 2), 1'b0, "R6 part2");

    // R8: reset mid-word restarts, and picks up the new order
    resetDut(1'b1);
    readStep(w, expPart(w, 1, 1, 1, 0), 1'b0, "R8 restart part0");
    readStep(w, expPart(w, 1, 1, 1, 1), 1'b0, "R8 restart part1");

    // halfword mid-word reset
    sizeSel = 1'b0;
    resetDut(1'b0);
    readStep(w, expPart(w, 1, 0, 0, 0), 1'b0, "R3 R8 half part0");
    resetDut(1'b0);
    readStep(w, expPart(w, 1, 0, 0, 0), 1'b0, "R8 half restart");
    readStep(w, expPart(w, 1, 0, 0, 1), 1'b1, "R3 half pop");

    @(negedge clk);
    csN = 1'b1; rdEn = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule